// File: doc/BRIEF.md
# Recirculating Serial Shift/Storage Register

The block pairs a 16-bit shift register with a 16-bit storage register whose contents drive a parallel output bus. One bidirectional serial line serves both directions. In serial-in mode the line feeds bits into the shift register. In serial-out mode the block drives bit 0 onto the line through a tri-state buffer, and that bit also wraps around into the top of the register. Sixteen shifts in serial-out mode therefore bring the register back to its starting contents.

A separate transfer strobe copies the whole shift register into storage. A load-back control copies storage into the shift register. An active-low chip select gates every register change. An asynchronous clear empties the storage register only.

All registers update on the falling edge of `clk_i`. The two register clocks are presented as strobes on that one clock: `shift_i` for the shift register and `xfer_i` for storage. The tri-state buffer is modelled as the pair `ser_o` and `ser_oe_o`.

Top module: `srss_shift_store`

## Requirements
- R1: While `rst_ni` is low, both registers clear. After reset, `par_o` reads 0 and `ser_o` reads 0.
- R2: A falling edge with `cs_ni`=0, `shift_i`=1, `load_back_i`=0 and `mode_i`=0 (serial-in) shifts the register right. Bit 15 takes `ser_i`, bit k takes old bit k+1, and old bit 0 is dropped.
- R3: `ser_o` always shows shift-register bit 0. The same edge with `mode_i`=1 (serial-out) rotates right, so old bit 0 re-enters at bit 15. Sixteen such edges restore the original contents.
- R4: `ser_oe_o` is 1 exactly when `cs_ni`=0 and `mode_i`=1, and is 0 otherwise.
- R5: A falling edge with `cs_ni`=0 and `xfer_i`=1 copies the shift register into storage, and `par_o` shows the stored value.
- R6: A falling edge with `cs_ni`=0, `shift_i`=1 and `load_back_i`=1 copies storage into the shift register. This takes priority over shifting in either mode.
- R7: With `cs_ni`=1, neither register changes on any edge, whatever the values of `shift_i`, `xfer_i` and `load_back_i`.
- R8: `clr_ni` low forces storage to zero at once, without waiting for a clock edge. It overrides a transfer on the same edge and leaves the shift register untouched.
- R9: A transfer and a shift on the same edge store the shift register's value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; registers update on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| mode_i | input | 1 | 0 = serial-in, 1 = serial-out (recirculate) |
| shift_i | input | 1 | Shift-clock strobe |
| load_back_i | input | 1 | With shift_i, load storage into shift register |
| xfer_i | input | 1 | Storage-transfer strobe |
| clr_ni | input | 1 | Active-low asynchronous storage clear |
| ser_i | input | 1 | Serial line value seen as input |
| ser_o | output | 1 | Serial line value driven (shift bit 0) |
| ser_oe_o | output | 1 | Serial line drive enable |
| par_o | output | 16 | Storage register contents |

## Verification
Three pairs of functions can act on the same falling edge:

- A shift and a transfer. The stimulus asserts `shift_i` and `xfer_i` together. The check requires storage to hold the value from before the shift, while the shift register takes the new bit.
- A load-back and a shift. The stimulus raises `load_back_i` with `shift_i` in both modes, with `ser_i` set to 1. The check requires the shift register to equal storage exactly.
- A clear and a transfer. The stimulus holds `clr_ni` low across an edge that carries `xfer_i`. The check requires `par_o` to stay zero. A later transfer then shows that the shift register was not disturbed.

// File: rtl/srss_pkg.sv
`timescale 1ns/1ps
package srss_pkg;
  typedef enum logic {
    MODE_SER_IN  = 1'b0,
    MODE_SER_OUT = 1'b1
  } ser_mode_e;
endpackage

// File: rtl/srss_shift_core.sv
`timescale 1ns/1ps
module srss_shift_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic         mode_i,
  input  logic         ser_i,
  input  logic [W-1:0] store_i,
  output logic [W-1:0] sh_o
);
  import srss_pkg::*;

  logic [W-1:0] sh_q, shifted;
  logic         head;

  // entry bit: external line or recirculated bit 0
  assign head = (ser_mode_e'(mode_i) == MODE_SER_OUT) ? sh_q[0] : ser_i;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W-1) begin : g_top
        assign shifted[i] = head;
      end else begin : g_mid
        assign shifted[i] = sh_q[i+1];
      end
    end
  endgenerate

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (en_i) begin
      if (load_i)    sh_q <= store_i;
      else           sh_q <= shifted;
    end
  end

  assign sh_o = sh_q;

  // R2
  shift_in_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !mode_i) |=> (sh_q == {$past(ser_i), $past(sh_q[W-1:1])}));
  // R3
  recirc_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && mode_i) |=> (sh_q == {$past(sh_q[0]), $past(sh_q[W-1:1])}));
  // R6
  load_back_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> (sh_q == $past(store_i)));
  // R7
  shift_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sh_q));
endmodule

// File: rtl/srss_store_reg.sv
`timescale 1ns/1ps
module srss_store_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         xfer_en_i,
  input  logic [W-1:0] sh_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;

  // clear wins over a transfer on the same edge
  always_ff @(negedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni || !clr_ni) st_q <= '0;
    else if (xfer_en_i)     st_q <= sh_i;
  end

  assign st_o = st_q;

  // R5
  xfer_copy_chk: assert property (@(negedge clk_i) disable iff (!rst_ni || !clr_ni)
    xfer_en_i |=> (st_q == $past(sh_i)));
  // R7
  store_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni || !clr_ni)
    !xfer_en_i |=> $stable(st_q));
  // R8
  clear_zero_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (st_q == '0));
endmodule

// File: rtl/srss_pin_ctrl.sv
`timescale 1ns/1ps
module srss_pin_ctrl (
  input  logic cs_ni,
  input  logic mode_i,
  input  logic bit0_i,
  output logic ser_o,
  output logic ser_oe_o
);
  import srss_pkg::*;

  assign ser_o    = bit0_i;
  assign ser_oe_o = !cs_ni && (ser_mode_e'(mode_i) == MODE_SER_OUT);
endmodule

// File: rtl/srss_shift_store.sv
`timescale 1ns/1ps
module srss_shift_store #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         mode_i,
  input  logic         shift_i,
  input  logic         load_back_i,
  input  logic         xfer_i,
  input  logic         clr_ni,
  input  logic         ser_i,
  output logic         ser_o,
  output logic         ser_oe_o,
  output logic [W-1:0] par_o
);
  logic [W-1:0] sh, st;
  logic         sh_en, xf_en;

  assign sh_en = !cs_ni && shift_i;
  assign xf_en = !cs_ni && xfer_i;

  srss_shift_core #(.W(W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sh_en),
    .load_i  (load_back_i),
    .mode_i  (mode_i),
    .ser_i   (ser_i),
    .store_i (st),
    .sh_o    (sh)
  );

  srss_store_reg #(.W(W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_ni    (clr_ni),
    .xfer_en_i (xf_en),
    .sh_i      (sh),
    .st_o      (st)
  );

  srss_pin_ctrl u_pin (
    .cs_ni    (cs_ni),
    .mode_i   (mode_i),
    .bit0_i   (sh[0]),
    .ser_o    (ser_o),
    .ser_oe_o (ser_oe_o)
  );

  assign par_o = st;

  // R9
  xfer_pre_shift_chk: assert property (@(negedge clk_i) disable iff (!rst_ni || !clr_ni)
    (xf_en && sh_en) |=> (par_o == $past(sh)));
endmodule

// File: tb/srss_shift_store_tb.sv
`timescale 1ns/1ps
module srss_shift_store_tb;
  localparam int W = 16;
  // {cs_n, mode, shift, load_back, xfer, ser}
  localparam int NV = 20;
  localparam logic [5:0] VEC [NV] = '{
    6'b001001, 6'b001000, 6'b001001, 6'b001001, 6'b001000,
    6'b001001, 6'b000010, 6'b001011, 6'b011000, 6'b011000,
    6'b101001, 6'b100010, 6'b111100, 6'b001100, 6'b001101,
    6'b011100, 6'b011010, 6'b010001, 6'b001001, 6'b000010
  };

  logic clk_i = 1'b1;
  logic rst_ni, cs_ni, mode_i, shift_i, load_back_i, xfer_i, clr_ni, ser_i;
  logic ser_o, ser_oe_o;
  logic [W-1:0] par_o;
  logic [W-1:0] sh_m, st_m;
  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  srss_shift_store #(.W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .mode_i(mode_i),
    .shift_i(shift_i), .load_back_i(load_back_i), .xfer_i(xfer_i),
    .clr_ni(clr_ni), .ser_i(ser_i), .ser_o(ser_o), .ser_oe_o(ser_oe_o),
    .par_o(par_o)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    check("R5 R7 R9 par_o", par_o, st_m);
    check("R2 R3 R6 ser_o", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, sh_m[0]});
    check("R4 ser_oe_o", {{(W-1){1'b0}}, ser_oe_o},
          {{(W-1){1'b0}}, (!cs_ni && mode_i)});
  endtask

  // drive, cross one falling edge, update model, compare
  task automatic step(input logic [5:0] v);
    logic [W-1:0] nsh, nst;
    {cs_ni, mode_i, shift_i, load_back_i, xfer_i, ser_i} = v;
    nsh = sh_m;
    nst = st_m;
    if (!cs_ni) begin
      if (shift_i) begin
        if (load_back_i) nsh = st_m;
        else if (mode_i) nsh = {sh_m[0], sh_m[W-1:1]};
        else             nsh = {ser_i, sh_m[W-1:1]};
      end
      if (xfer_i) nst = sh_m;
    end
    @(negedge clk_i);
    #2;
    sh_m = nsh;
    st_m = nst;
    check_all();
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    rst_ni = 1'b0; cs_ni = 1'b1; mode_i = 1'b0; shift_i = 1'b0;
    load_back_i = 1'b0; xfer_i = 1'b0; clr_ni = 1'b1; ser_i = 1'b0;
    sh_m = '0; st_m = '0;
    repeat (2) @(negedge clk_i);
    #2;
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 par_o", par_o, '0);
    check("R1 ser_o", {{(W-1){1'b0}}, ser_o}, '0);
    check("R1 ser_oe_o", {{(W-1){1'b0}}, ser_oe_o}, '0);

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // R3: load a pattern, rotate 16 times, transfer, expect pattern back
    pat = 16'hA5C3;
    for (int i = 0; i < W; i++) step({5'b00100, pat[i]});
    step(6'b000010);
    check("R2 serial fill", par_o, pat);
    for (int i = 0; i < W; i++) begin
      check("R3 ser_o order", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, pat[i]});
      step(6'b011000);
    end
    step(6'b000010);
    check("R3 restored after 16", par_o, pat);

    // R8: asynchronous clear, visible before any edge
    clr_ni = 1'b0;
    #1;
    st_m = '0;
    check("R8 async clear", par_o, '0);
    // R8: clear held over an edge carrying a transfer
    {cs_ni, mode_i, shift_i, load_back_i, xfer_i, ser_i} = 6'b000010;
    @(negedge clk_i);
    #2;
    check("R8 clear beats xfer", par_o, '0);
    clr_ni = 1'b1;
    step(6'b000010);
    check("R8 shift reg untouched", par_o, pat);

    // R7: chip select high blocks everything
    step(6'b101111);
    check("R7 blocked", par_o, pat);

    // R6: load-back priority over serial-in with ser=1 after shifting
    step(6'b001001);
    step(6'b001101);
    step(6'b000010);
    check("R6 load-back priority", par_o, pat);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule